// File: doc/BRIEF.md
# SD Command Line Controller

This block drives the single command wire of an SD card bus. When the register side raises a start request, it builds a 48-bit command packet from a 6-bit command index and a 32-bit argument. It sends the packet one bit per SD bit slot and computes the 7-bit CRC while the bits go out. Depending on the response kind latched with the request, it then either returns to idle or releases the wire and waits for the card's reply. While it waits, a fixed 64-slot timeout runs.

A reply begins with a low start bit. From that bit on, the controller counts and shifts in 48 or 136 bits. It then checks the CRC, the end bit and (for 48-bit replies) the echoed command index, and presents the payload bits together with sticky error flags. One-cycle strobes mark the end of the command and the end of the response, so that a data-path controller can start its own transfer. The block runs entirely on the system clock. An SD bit slot is marked by the `bit_en` clock enable, which comes from the clock divider outside the block.

Top module: `sd_cmd_line_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, `cmd_oe` is 0, `cmd_out` is 1, `busy` is 0, all error flags and strobes are 0 and `resp_data` is zero; an asynchronous reset in the middle of a command returns the block to this state at once.
- R2: An accepted request sends exactly 48 bits, one per `bit_en` slot and most significant bit first: a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument, 7 CRC bits and a 1 end bit; `cmd_oe` is 1 during exactly these 48 slots.
- R3: The transmitted CRC is the CRC7 with generator x^7+x^3+1, starting from zero and covering the first 40 packet bits (for example index 0 with argument 0 yields CRC 7'h4A).
- R4: `cmd_end` pulses for one cycle right after the 48th bit slot; with `resp_type` = 2'b00 the block is idle at that point and `resp_end` never pulses.
- R5: With a response expected, if 64 consecutive sampled slots show the line high, `timeout_err` is set and the block goes idle without `resp_end`; a start bit seen in the 64th slot is still accepted.
- R6: With `resp_type` = 2'b01, reception ends after 48 bits counted from the start bit, `resp_end` pulses for one cycle and `resp_data[31:0]` holds received bits 39..8 with the upper bits zero.
- R7: With `resp_type` = 2'b10 or 2'b11, reception ends after 136 bits, `resp_data` holds received bits 127..8, and the index field (bits 133..128) is never checked.
- R8: `crc_err` is set when received bits 7..1 differ from the CRC7 over bits 47..8 (48-bit reply) or bits 127..8 (136-bit reply).
- R9: For a 48-bit reply, `index_err` is set when received bits 45..40 differ from the command index that was sent.
- R10: `endbit_err` is set when the last received bit is 0.
- R11: `start_req` is ignored while `busy` is 1; an accepted request clears all four error flags.
- R12: Nothing advances in a cycle without `bit_en`: the line outputs hold, and the response timeout counts bit slots, not clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One SD bit slot per high cycle |
| start_req | input | 1 | Request to send a command (taken when idle) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_type | input | 2 | 00 none, 01 48-bit reply, 1x 136-bit reply |
| cmd_in | input | 1 | Sampled command wire |
| cmd_out | output | 1 | Value driven on the command wire |
| cmd_oe | output | 1 | Output enable for the command wire |
| busy | output | 1 | A command or response is in progress |
| cmd_end | output | 1 | One-cycle strobe after the last command bit |
| resp_end | output | 1 | One-cycle strobe after the last reply bit |
| timeout_err | output | 1 | No start bit within 64 slots |
| crc_err | output | 1 | Reply CRC mismatch |
| index_err | output | 1 | Reply index mismatch (48-bit reply) |
| endbit_err | output | 1 | Reply end bit was 0 |
| resp_data | output | 120 | Received reply payload |

## Verification
A corrupted transmit shift register or CRC register shows up on `cmd_out` inside the same 48-slot frame, at the first wrong bit. A wrong bit counter shows up as `cmd_end` or `resp_end` arriving in the wrong slot, or as `cmd_oe` held for more or fewer than 48 slots. A receive-side fault cannot be seen until the reply finishes, because the flags and `resp_data` only update on the `resp_end` cycle. The bench therefore checks them exactly there. A timeout counter that is off by one is caught by the reply whose start bit arrives in the 64th slot.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int IDX_W    = 6;
  localparam int ARG_W    = 32;
  localparam int CRC_W    = 7;
  localparam int CMD_W    = 48;
  localparam int BODY_W   = CMD_W - CRC_W - 1;
  localparam int SHORT_W  = 48;
  localparam int LONG_W   = 136;
  localparam int LONG_HDR = 8;
  localparam int RESP_W   = LONG_W - 2 * LONG_HDR;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV
  } cmd_state_e;

  // One serial step of CRC7, generator x^7 + x^3 + 1.
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic d);
    logic fb;
    fb = d ^ c[CRC_W-1];
    return {c[5:3], c[2] ^ fb, c[1:0], fb};
  endfunction
endpackage

// File: rtl/sd_crc7.sv
module sd_crc7
  import sd_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             shout,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] crc_d;

  always_comb begin
    crc_d = crc;
    if (clr)        crc_d = '0;
    else if (en)    crc_d = crc7_step(crc, din);
    else if (shout) crc_d = {crc[CRC_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= '0;
    else        crc <= crc_d;
  end
endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
  import sd_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             txd,
  output logic             last
);
  localparam int CW = $clog2(CMD_W);
  localparam logic [CW-1:0] BODY_END = CW'(BODY_W);
  localparam logic [CW-1:0] PKT_LAST = CW'(CMD_W - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [BODY_W-1:0] sr, sr_d;
  logic [CW-1:0]     cnt, cnt_d;
  logic [CRC_W-1:0]  crc;
  logic              in_body;
  logic              crc_en, crc_shout;

  assign in_body   = cnt < BODY_END;
  assign crc_en    = shift && in_body;
  assign crc_shout = shift && !in_body;
  assign last      = shift && (cnt == PKT_LAST);

  always_comb begin
    if (in_body)               txd = sr[BODY_W-1];
    else if (cnt != PKT_LAST)  txd = crc[CRC_W-1];
    else                       txd = 1'b1;
  end

  always_comb begin
    sr_d  = sr;
    cnt_d = cnt;
    if (load) begin
      sr_d  = {1'b0, 1'b1, idx, arg};
      cnt_d = '0;
    end else if (shift) begin
      sr_d  = {sr[BODY_W-2:0], 1'b0};
      cnt_d = cnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else begin
      sr  <= sr_d;
      cnt <= cnt_d;
    end
  end

  sd_crc7 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load),
    .en    (crc_en),
    .shout (crc_shout),
    .din   (sr[BODY_W-1]),
    .crc   (crc)
  );
endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
  import sd_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              long_sel,
  input  logic              din,
  output logic              last,
  output logic              crc_bad,
  output logic              end_bad,
  output logic [IDX_W-1:0]  rx_idx,
  output logic [RESP_W-1:0] rx_data
);
  localparam int CW = $clog2(LONG_W + 1);
  localparam logic [CW-1:0] ONE = CW'(1);

  // sr[k-1] holds packet bit k when the final bit arrives on din.
  logic [LONG_W-2:0] sr, sr_d;
  logic [CW-1:0]     cnt, cnt_d;
  logic [CW-1:0]     len, lo, hi;
  logic [CRC_W-1:0]  crc;
  logic              crc_en;

  always_comb begin
    len = long_sel ? CW'(LONG_W) : CW'(SHORT_W);
    lo  = long_sel ? CW'(LONG_HDR) : '0;
    hi  = long_sel ? CW'(LONG_W - LONG_HDR) : CW'(SHORT_W - LONG_HDR);
  end

  assign crc_en  = take && (cnt >= lo) && (cnt < hi);
  assign last    = take && (cnt == len - ONE);
  assign crc_bad = sr[CRC_W-1:0] != crc;
  assign end_bad = !din;
  assign rx_idx  = sr[SHORT_W-4 -: IDX_W];
  assign rx_data = long_sel ? sr[LONG_W-10:LONG_HDR-1]
                            : {{(RESP_W-ARG_W){1'b0}}, sr[SHORT_W-10:LONG_HDR-1]};

  always_comb begin
    sr_d  = sr;
    cnt_d = cnt;
    if (clr) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (take) begin
      sr_d  = {sr[LONG_W-3:0], din};
      cnt_d = cnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else begin
      sr  <= sr_d;
      cnt <= cnt_d;
    end
  end

  sd_crc7 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .en    (crc_en),
    .shout (1'b0),
    .din   (din),
    .crc   (crc)
  );
endmodule

// File: rtl/sd_cmd_line_ctrl.sv
module sd_cmd_line_ctrl
  import sd_cmd_pkg::*;
#(
  parameter int TIMEOUT_SLOTS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              start_req,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic [1:0]        resp_type,
  input  logic              cmd_in,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic              busy,
  output logic              cmd_end,
  output logic              resp_end,
  output logic              timeout_err,
  output logic              crc_err,
  output logic              index_err,
  output logic              endbit_err,
  output logic [RESP_W-1:0] resp_data
);
  localparam int TW = $clog2(TIMEOUT_SLOTS);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_SLOTS - 1);
  localparam logic [TW-1:0] T_ONE  = TW'(1);

  cmd_state_e        st, st_d;
  logic [TW-1:0]     tcnt, tcnt_d;
  logic              want_q, want_d, long_q, long_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              to_d, crc_d, ie_d, eb_d;
  logic [RESP_W-1:0] data_d;

  logic              accept, tx_shift, tx_last, txd;
  logic              rx_take, rx_last, rx_crc_bad, rx_end_bad;
  logic [IDX_W-1:0]  rx_idx;
  logic [RESP_W-1:0] rx_data;

  assign accept   = (st == ST_IDLE) && start_req;
  assign tx_shift = (st == ST_SEND) && bit_en;
  assign rx_take  = bit_en && (((st == ST_WAIT) && !cmd_in) || (st == ST_RECV));
  assign cmd_oe   = (st == ST_SEND);
  assign cmd_out  = (st == ST_SEND) ? txd : 1'b1;
  assign busy     = (st != ST_IDLE);

  always_comb begin
    st_d   = st;
    tcnt_d = tcnt;
    want_d = want_q;
    long_d = long_q;
    idx_d  = idx_q;
    to_d   = timeout_err;
    crc_d  = crc_err;
    ie_d   = index_err;
    eb_d   = endbit_err;
    data_d = resp_data;
    case (st)
      ST_IDLE: if (start_req) begin
        st_d   = ST_SEND;
        want_d = (resp_type != 2'b00);
        long_d = resp_type[1];
        idx_d  = cmd_index;
        tcnt_d = '0;
        to_d   = 1'b0;
        crc_d  = 1'b0;
        ie_d   = 1'b0;
        eb_d   = 1'b0;
      end
      ST_SEND: if (tx_last) st_d = want_q ? ST_WAIT : ST_IDLE;
      ST_WAIT: if (bit_en) begin
        if (!cmd_in) begin
          st_d = ST_RECV;
        end else if (tcnt == T_LAST) begin
          st_d = ST_IDLE;
          to_d = 1'b1;
        end else begin
          tcnt_d = tcnt + T_ONE;
        end
      end
      ST_RECV: if (rx_last) begin
        st_d   = ST_IDLE;
        crc_d  = rx_crc_bad;
        eb_d   = rx_end_bad;
        ie_d   = !long_q && (rx_idx != idx_q);
        data_d = rx_data;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      tcnt        <= '0;
      want_q      <= 1'b0;
      long_q      <= 1'b0;
      idx_q       <= '0;
      timeout_err <= 1'b0;
      crc_err     <= 1'b0;
      index_err   <= 1'b0;
      endbit_err  <= 1'b0;
      resp_data   <= '0;
      cmd_end     <= 1'b0;
      resp_end    <= 1'b0;
    end else begin
      st          <= st_d;
      tcnt        <= tcnt_d;
      want_q      <= want_d;
      long_q      <= long_d;
      idx_q       <= idx_d;
      timeout_err <= to_d;
      crc_err     <= crc_d;
      index_err   <= ie_d;
      endbit_err  <= eb_d;
      resp_data   <= data_d;
      cmd_end     <= tx_last;
      resp_end    <= rx_last;
    end
  end

  sd_cmd_tx u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .shift (tx_shift),
    .idx   (cmd_index),
    .arg   (cmd_arg),
    .txd   (txd),
    .last  (tx_last)
  );

  sd_cmd_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .take     (rx_take),
    .long_sel (long_q),
    .din      (cmd_in),
    .last     (rx_last),
    .crc_bad  (rx_crc_bad),
    .end_bad  (rx_end_bad),
    .rx_idx   (rx_idx),
    .rx_data  (rx_data)
  );
endmodule

// File: rtl/sd_cmd_line_ctrl_chk.sv
module sd_cmd_line_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic start_req,
  input logic cmd_out,
  input logic cmd_oe,
  input logic busy,
  input logic cmd_end,
  input logic resp_end,
  input logic timeout_err,
  input logic crc_err,
  input logic index_err,
  input logic endbit_err
);
  assert_oe_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy);

  assert_frame_opens_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out);

  assert_cmd_end_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end |-> !cmd_oe);

  assert_timeout_goes_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (!busy && !resp_end));

  assert_resp_end_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_end |-> (!busy && !timeout_err && !cmd_oe));

  assert_accept_clears_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_req) |=> (busy && !timeout_err && !crc_err && !index_err && !endbit_err));

  assert_hold_without_slot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> ($stable(cmd_oe) && $stable(cmd_out)));
endmodule

bind sd_cmd_line_ctrl sd_cmd_line_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_en      (bit_en),
  .start_req   (start_req),
  .cmd_out     (cmd_out),
  .cmd_oe      (cmd_oe),
  .busy        (busy),
  .cmd_end     (cmd_end),
  .resp_end    (resp_end),
  .timeout_err (timeout_err),
  .crc_err     (crc_err),
  .index_err   (index_err),
  .endbit_err  (endbit_err)
);

// File: tb/sd_cmd_line_ctrl_test.sv
module sd_cmd_line_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n, bit_en, start_req, cmd_in;
  logic [5:0]   cmd_index;
  logic [31:0]  cmd_arg;
  logic [1:0]   resp_type;
  logic         cmd_out, cmd_oe, busy, cmd_end, resp_end;
  logic         timeout_err, crc_err, index_err, endbit_err;
  logic [119:0] resp_data;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sd_cmd_line_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start_req(start_req),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .resp_type(resp_type),
    .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy),
    .cmd_end(cmd_end), .resp_end(resp_end), .timeout_err(timeout_err),
    .crc_err(crc_err), .index_err(index_err), .endbit_err(endbit_err),
    .resp_data(resp_data)
  );

  // index, argument, response kind, start-bit delay (>=64: none), fault kind
  // fault: 0 clean, 1 CRC bit flipped, 2 index field altered, 3 end bit low
  localparam int NV = 11;
  localparam logic [48:0] VEC [NV] = '{
    {6'd0,  32'h00000000, 2'd0, 7'd0,  2'd0},
    {6'd8,  32'h000001AA, 2'd1, 7'd2,  2'd0},
    {6'd17, 32'h00001000, 2'd1, 7'd0,  2'd0},
    {6'd2,  32'h00000000, 2'd2, 7'd5,  2'd0},
    {6'd55, 32'h12340000, 2'd1, 7'd63, 2'd0},
    {6'd13, 32'hABCD0000, 2'd1, 7'd64, 2'd0},
    {6'd17, 32'h00000200, 2'd1, 7'd1,  2'd1},
    {6'd8,  32'h000001AA, 2'd1, 7'd3,  2'd2},
    {6'd9,  32'h55550000, 2'd3, 7'd4,  2'd3},
    {6'd9,  32'h55550000, 2'd2, 7'd2,  2'd1},
    {6'd3,  32'h00000000, 2'd2, 7'd3,  2'd2}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bitwise CRC7 over pkt[hi] down to pkt[lo], generator 0x09.
  function automatic logic [6:0] ref_crc(input logic [135:0] pkt, input int hi, input int lo);
    logic [6:0] c;
    c = 7'h00;
    for (int i = hi; i >= lo; i--) begin
      logic fb;
      fb = pkt[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic slot(input logic din, output logic o_oe, output logic o_out);
    @(negedge clk);
    bit_en = 1'b1;
    cmd_in = din;
    o_oe   = cmd_oe;
    o_out  = cmd_out;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt);
    @(negedge clk);
    cmd_index = idx;
    cmd_arg   = arg;
    resp_type = rt;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk(busy === 1'b1 && {timeout_err, crc_err, index_err, endbit_err} === 4'b0,
        "R11", "accept clears flags", {busy, timeout_err, crc_err, index_err, endbit_err}, 5'b10000);
  endtask

  task automatic run_txn(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt,
                         input int dly, input int fault, input int glitch, input int gap,
                         output logic [47:0] frm);
    logic [47:0]  exp_f;
    logic [135:0] r;
    logic [119:0] p, exp_d;
    logic         oe, o;
    int           bad, n, ndly;
    bit           lng;
    exp_f = {2'b01, idx, arg, 8'h01};
    exp_f[7:1] = ref_crc({88'b0, exp_f}, 47, 8);
    frm = '0;
    issue(idx, arg, rt);
    bad = 0;
    for (int i = 0; i < 48; i++) begin
      if (i == glitch) begin
        start_req = 1'b1;
        cmd_index = idx ^ 6'h05;
        cmd_arg   = ~arg;
      end
      slot(1'b1, oe, o);
      start_req = 1'b0;
      frm[47-i] = o;
      if (oe !== 1'b1 || o !== exp_f[47-i]) bad++;
    end
    chk(bad == 0, "R2", "command frame", {80'b0, frm}, {80'b0, exp_f});
    chk(cmd_end === 1'b1, "R4", "cmd_end after 48th slot", cmd_end, 1);
    if (rt == 2'b00) begin
      chk(busy === 1'b0 && resp_end === 1'b0, "R4", "idle without reply", {busy, resp_end}, 0);
      return;
    end
    if (gap > 0) begin
      repeat (gap) @(negedge clk);
      chk(busy === 1'b1 && timeout_err === 1'b0 && cmd_oe === 1'b0, "R12",
          "no progress without bit_en", {busy, timeout_err, cmd_oe}, 3'b100);
    end
    ndly = (dly >= 64) ? 64 : dly;
    bad = 0;
    for (int i = 0; i < ndly; i++) begin
      slot(1'b1, oe, o);
      if (oe !== 1'b0) bad++;
    end
    if (dly >= 64) begin
      chk(timeout_err === 1'b1 && busy === 1'b0 && resp_end === 1'b0, "R5",
          "timeout after 64 high slots", {timeout_err, busy, resp_end}, 3'b100);
      return;
    end
    lng = rt[1];
    p = {arg ^ 32'h5A5AC3C3, ~arg, arg ^ 32'h0F0F1234, arg[23:0]};
    r = '0;
    if (lng) begin
      r = {2'b00, (fault == 2) ? 6'h00 : 6'h3F, p, 8'h01};
      r[7:1] = ref_crc(r, 127, 8);
      n = 136;
      exp_d = p;
    end else begin
      r[47:0] = {2'b00, (fault == 2) ? (idx ^ 6'h01) : idx, p[31:0], 8'h01};
      r[7:1] = ref_crc(r, 47, 8);
      n = 48;
      exp_d = {88'b0, p[31:0]};
    end
    if (fault == 1) r[1] = ~r[1];
    if (fault == 3) r[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      slot(r[n-1-i], oe, o);
      if (oe !== 1'b0) bad++;
    end
    cmd_in = 1'b1;
    chk(bad == 0, "R6", "line released during reply", bad, 0);
    chk(resp_end === 1'b1 && busy === 1'b0, lng ? "R7" : "R6", "resp_end after last reply bit",
        {resp_end, busy}, 2'b10);
    chk(resp_data === exp_d, lng ? "R7" : "R6", "payload", {8'b0, resp_data}, {8'b0, exp_d});
    chk(crc_err === (fault == 1), "R8", "crc flag", crc_err, (fault == 1));
    chk(index_err === (fault == 2 && !lng), lng ? "R7" : "R9", "index flag",
        index_err, (fault == 2 && !lng));
    chk(endbit_err === (fault == 3), "R10", "end bit flag", endbit_err, (fault == 3));
    chk(timeout_err === 1'b0, "R5", "no timeout when start bit seen", timeout_err, 0);
  endtask

  initial begin
    logic [47:0] frm;
    logic        oe, o;
    rst_n = 1'b0; bit_en = 1'b0; start_req = 1'b0; cmd_in = 1'b1;
    cmd_index = '0; cmd_arg = '0; resp_type = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_oe === 1'b0 && cmd_out === 1'b1 && busy === 1'b0 && cmd_end === 1'b0 &&
        resp_end === 1'b0 && {timeout_err, crc_err, index_err, endbit_err} === 4'b0 &&
        resp_data === '0, "R1", "reset state", {cmd_oe, cmd_out, busy}, 3'b010);

    for (int k = 0; k < NV; k++) begin
      logic [48:0] v;
      v = VEC[k];
      run_txn(v[48:43], v[42:11], v[10:9], int'(v[8:2]), int'(v[1:0]), -1, 0, frm);
      if (k == 0) chk(frm === 48'h400000000095, "R3", "CRC of index 0", frm, 48'h400000000095);
      if (k == 1) chk(frm === 48'h48000001AA87, "R3", "CRC of index 8", frm, 48'h48000001AA87);
    end

    // R11: a request raised mid-frame with other fields must not disturb it
    run_txn(6'd17, 32'h00000000, 2'd1, 0, 0, 10, 0, frm);
    chk(frm === 48'h510000000055, "R11", "frame unchanged by busy request", frm, 48'h510000000055);

    // R12: long pause without bit slots while waiting, then timeout in slots
    run_txn(6'd13, 32'h00010000, 2'd1, 64, 0, -1, 100, frm);

    // R1: asynchronous reset in the middle of a frame
    issue(6'd24, 32'hDEADBEEF, 2'd1);
    for (int i = 0; i < 5; i++) slot(1'b1, oe, o);
    rst_n = 1'b0;
    #1;
    chk(cmd_oe === 1'b0 && cmd_out === 1'b1 && busy === 1'b0, "R1", "reset mid-frame",
        {cmd_oe, cmd_out, busy}, 3'b010);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_txn(6'd8, 32'h000001AA, 2'd1, 2, 0, -1, 0, frm);
    chk(frm === 48'h48000001AA87, "R1", "clean frame after reset", frm, 48'h48000001AA87);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual still running, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule